// File: doc/BRIEF.md
# Dual Event Performance Counter Unit

This block gives a processor core two independent event counters for profiling. The core presents a 64-bit vector of single-cycle event pulses, indexed by a 6-bit event code. Each counter has a 16-bit control word. The control word picks one code, gates counting with two run bits, selects the time base for the elapsed-cycle event, and can zero the count through a self-clearing bit. A count cannot be loaded with an arbitrary value.

Each count is `CNT_W` bits wide, 48 by default. Software reads it as two 32-bit words through a small synchronous register port. Writes are accepted in the cycle they are presented. Read data is registered and appears one cycle after the address. When a count reaches all ones it wraps to zero without any notification. The block has no interrupt output.

Top module: `evt_perf_unit`

## Requirements
- R1: Word addresses are: 0 control of counter A, 1 control of counter B, 2 A high word, 3 A low word, 4 B high word, 5 B low word. Addresses 6 and 7 read zero. `rd_data_o` shows the word addressed in the previous cycle.
- R2: The control word holds these fields: [5:0] event code, [8] time-base select, [13] clear, [14] start, [15] enable. Every bit except 13 is stored and reads back in `rd_data_o[15:0]`, with bits 31:16 reading zero. The other stored bits (7:6, 12:9) have no effect on counting.
- R3: A counter adds one on a clock edge only when its start bit and its enable bit are both 1 and its selected event is active. Clearing either bit freezes the count at its current value.
- R4: A write with bit 13 set zeroes that counter at the same edge that stores the new control value. A clear overrides an increment on that edge. Bit 13 always reads back as 0.
- R5: For an assigned code c other than 0x23, the counter adds one for each cycle in which `evt_i[c]` is 1. Pulses on all other event lines are ignored. The assigned codes are 0x01–0x0B, 0x0D–0x1A, 0x21–0x25 and 0x27–0x29.
- R6: The unassigned codes select no event, so the count holds. These codes are 0x00, 0x0C, 0x1B–0x20, 0x26 and 0x2A–0x3F.
- R7: Code 0x23 is elapsed time. With bit 8 = 0 it counts every cycle. With bit 8 = 1 it counts only the cycles in which `tick_i` is 1. In both cases `evt_i[35]` is ignored.
- R8: The low word returns count[31:0]. The high word returns count[47:32] in bits 15:0, and its bits 31:16 are zero. Count bits at or above `CNT_W` read as zero.
- R9: An increment from all ones gives zero, and no other output changes.
- R10: After reset, both control words and both counts are zero, and `rd_data_o` is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 3 | Word address for read and write |
| wr_en_i | input | 1 | Write strobe; writes go to control words only |
| wr_data_i | input | 16 | Control word write data |
| rd_data_o | output | 32 | Registered read data |
| evt_i | input | 64 | Event pulses; bit c is the event with code c |
| tick_i | input | 1 | Prescaled time-base tick for the elapsed event |

## Verification
The assertions check the following on every cycle for both counters:
- a clear leaves the count at zero on the next edge;
- the count moves only on an increment, and then by exactly one modulo 2^CNT_W, which includes the wrap;
- no increment happens unless both run bits are set;
- the stored clear bit is never 1;
- the upper half of a high-word read is zero.

Some behaviours only the bench scenarios can show. These are the code-to-event mapping across all 64 codes, the ignoring of every non-selected line, the two time bases of the elapsed event, the independence of the two counters, and the exact wrap value. The wrap is reached on a second instance with a 6-bit count.

// File: rtl/evpc_pkg.sv
package evpc_pkg;
  localparam int unsigned CODE_W  = 6;
  localparam int unsigned EVT_W   = 1 << CODE_W;
  localparam int unsigned CTRL_W  = 16;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned NUM_CTR = 2;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned VIEW_W  = 48;

  localparam int unsigned BIT_TSRC  = 8;
  localparam int unsigned BIT_CLR   = 13;
  localparam int unsigned BIT_START = 14;
  localparam int unsigned BIT_EN    = 15;

  localparam logic [CODE_W-1:0] CODE_ELAPSED = 6'h23;

  // Codes with an event behind them; everything else selects nothing.
  function automatic logic code_assigned(input logic [CODE_W-1:0] c);
    logic ok;
    ok = (c >= 6'h01) && (c <= 6'h29);
    if (c == 6'h0C || c == 6'h26) ok = 1'b0;
    if (c >= 6'h1B && c <= 6'h20) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic [WORD_W-1:0] high_word(input logic [VIEW_W-1:0] v);
    return {16'h0000, v[VIEW_W-1:WORD_W]};
  endfunction

  function automatic logic [WORD_W-1:0] low_word(input logic [VIEW_W-1:0] v);
    return v[WORD_W-1:0];
  endfunction
endpackage

// File: rtl/evpc_event_sel.sv
module evpc_event_sel
  import evpc_pkg::*;
(
  input  logic [EVT_W-1:0]  evt_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              tsrc_i,
  input  logic              tick_i,
  output logic              hit_o
);
  always_comb begin
    if (!code_assigned(code_i)) begin
      hit_o = 1'b0;
    end else if (code_i == CODE_ELAPSED) begin
      hit_o = tsrc_i ? tick_i : 1'b1;
    end else begin
      hit_o = evt_i[code_i];
    end
  end
endmodule

// File: rtl/evpc_counter.sv
module evpc_counter #(
  parameter int unsigned CNT_W = 48
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o
);
  function automatic logic [CNT_W-1:0] step(input logic [CNT_W-1:0] v);
    return v + CNT_W'(1);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
    end else if (clr_i) begin
      cnt_o <= '0;
    end else if (inc_i) begin
      cnt_o <= step(cnt_o);
    end
  end
endmodule

// File: rtl/evt_perf_unit.sv
module evt_perf_unit
  import evpc_pkg::*;
#(
  parameter int unsigned CNT_W = 48
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                wr_en_i,
  input  logic [CTRL_W-1:0]   wr_data_i,
  output logic [WORD_W-1:0]   rd_data_o,
  input  logic [EVT_W-1:0]    evt_i,
  input  logic                tick_i
);
  localparam logic [CTRL_W-1:0] STORE_MASK = ~(CTRL_W'(1) << BIT_CLR);

  logic [CTRL_W-1:0] ctrl_q [NUM_CTR];
  logic [CNT_W-1:0]  cnt_w  [NUM_CTR];
  logic [NUM_CTR-1:0] sel_w;
  logic [NUM_CTR-1:0] clr_w;
  logic [NUM_CTR-1:0] run_w;
  logic [NUM_CTR-1:0] hit_w;
  logic [NUM_CTR-1:0] inc_w;
  logic [WORD_W-1:0]  rd_next;

  function automatic logic [VIEW_W-1:0] widen(input logic [CNT_W-1:0] v);
    logic [VIEW_W-1:0] r;
    r = '0;
    r[CNT_W-1:0] = v;
    return r;
  endfunction

  for (genvar k = 0; k < NUM_CTR; k++) begin : g_ctr
    assign sel_w[k] = wr_en_i && (addr_i == ADDR_W'(k));
    assign clr_w[k] = sel_w[k] && wr_data_i[BIT_CLR];
    assign run_w[k] = ctrl_q[k][BIT_START] && ctrl_q[k][BIT_EN];
    assign inc_w[k] = run_w[k] && hit_w[k];

    evpc_event_sel u_sel (
      .evt_i  (evt_i),
      .code_i (ctrl_q[k][CODE_W-1:0]),
      .tsrc_i (ctrl_q[k][BIT_TSRC]),
      .tick_i (tick_i),
      .hit_o  (hit_w[k])
    );

    evpc_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_w[k]),
      .inc_i  (inc_w[k]),
      .cnt_o  (cnt_w[k])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NUM_CTR; k++) ctrl_q[k] <= '0;
    end else begin
      for (int k = 0; k < NUM_CTR; k++) begin
        if (sel_w[k]) ctrl_q[k] <= wr_data_i & STORE_MASK;
      end
    end
  end

  always_comb begin
    case (addr_i)
      3'd0:    rd_next = {16'h0000, ctrl_q[0]};
      3'd1:    rd_next = {16'h0000, ctrl_q[1]};
      3'd2:    rd_next = high_word(widen(cnt_w[0]));
      3'd3:    rd_next = low_word(widen(cnt_w[0]));
      3'd4:    rd_next = high_word(widen(cnt_w[1]));
      3'd5:    rd_next = low_word(widen(cnt_w[1]));
      default: rd_next = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_data_o <= '0;
    else         rd_data_o <= rd_next;
  end
endmodule

// File: rtl/evpc_checker.sv
module evpc_checker
  import evpc_pkg::*;
#(
  parameter int unsigned CNT_W = 48
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WORD_W-1:0] rd_data_o,
  input logic [CTRL_W-1:0] ctrl_a,
  input logic [CTRL_W-1:0] ctrl_b,
  input logic              clr_a,
  input logic              clr_b,
  input logic              inc_a,
  input logic              inc_b,
  input logic [CNT_W-1:0]  cnt_a,
  input logic [CNT_W-1:0]  cnt_b
);
  a_r4_clear_zeroes_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_a |=> (cnt_a == '0));
  a_r4_clear_zeroes_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_b |=> (cnt_b == '0));
  a_r4_clear_not_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_a[BIT_CLR] && !ctrl_b[BIT_CLR]);
  a_r3_needs_run_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_a |-> (ctrl_a[BIT_START] && ctrl_a[BIT_EN]));
  a_r3_needs_run_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_b |-> (ctrl_b[BIT_START] && ctrl_b[BIT_EN]));
  a_r3_hold_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_a && !clr_a) |=> $stable(cnt_a));
  a_r3_hold_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_b && !clr_b) |=> $stable(cnt_b));
  a_r9_step_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_a && !clr_a) |=> (cnt_a == CNT_W'($past(cnt_a) + CNT_W'(1))));
  a_r9_step_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_b && !clr_b) |=> (cnt_b == CNT_W'($past(cnt_b) + CNT_W'(1))));
  a_r8_high_upper_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(addr_i) == 3'd2 || $past(addr_i) == 3'd4) |-> (rd_data_o[31:16] == 16'h0000));
endmodule

bind evt_perf_unit evpc_checker #(.CNT_W(CNT_W)) u_evpc_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .addr_i    (addr_i),
  .rd_data_o (rd_data_o),
  .ctrl_a    (ctrl_q[0]),
  .ctrl_b    (ctrl_q[1]),
  .clr_a     (clr_w[0]),
  .clr_b     (clr_w[1]),
  .inc_a     (inc_w[0]),
  .inc_b     (inc_w[1]),
  .cnt_a     (cnt_w[0]),
  .cnt_b     (cnt_w[1])
);

// File: tb/test_evt_perf_unit.sv
module test_evt_perf_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [15:0] wdata = '0;
  logic [63:0] evt = '0;
  logic        tick = 1'b0;
  logic [31:0] rdata, rdata_n;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [15:0] RUN = 16'hC000;
  localparam logic [15:0] CLR = 16'h2000;
  localparam logic [15:0] TSRC = 16'h0100;

  always #4 clk = ~clk;

  evt_perf_unit i_evt_perf_unit (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wdata), .rd_data_o(rdata), .evt_i(evt), .tick_i(tick));

  evt_perf_unit #(.CNT_W(6)) i_evt_perf_unit_narrow (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wr_en_i(wr_en),
    .wr_data_i(wdata), .rd_data_o(rdata_n), .evt_i(evt), .tick_i(tick));

  function automatic bit has_event(input int c);
    case (c) inside
      [1:11], [13:26], [33:37], [39:41]: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    addr = a; wr_en = 1'b1; wdata = d;
    @(posedge clk); @(negedge clk);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d, output logic [31:0] dn);
    addr = a;
    @(posedge clk); @(negedge clk);
    d = rdata; dn = rdata_n;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, vn;
    logic [7:0] pat;
    pat = 8'b0010_1101;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state, R1 unmapped addresses
    for (int a = 0; a < 6; a++) begin
      rd(3'(a), v, vn);
      chk($sformatf("R10 reset word %0d", a), v, 32'h0);
    end
    rd(3'd6, v, vn); chk("R1 unmapped 6", v, 32'h0);
    rd(3'd7, v, vn); chk("R1 unmapped 7", v, 32'h0);

    // R5/R6 sweep over all codes; counter B on a neighbour code
    for (int c = 0; c < 64; c++) begin
      int d;
      if (c == 35) continue;
      d = c ^ 1;
      if (d == 35) d = 1;
      evt = '0;
      wr(3'd1, RUN | CLR | 16'(d));
      wr(3'd0, RUN | CLR | 16'(c));
      for (int j = 0; j < 8; j++) begin
        evt = ~(64'd1 << c) | (pat[j] ? (64'd1 << c) : 64'd0);
        @(negedge clk);
      end
      evt = '0;
      wr(3'd0, 16'(c));
      wr(3'd1, 16'(d));
      rd(3'd3, v, vn);
      chk($sformatf("%s counter A code %0h", has_event(c) ? "R5" : "R6", c), v,
          has_event(c) ? 32'd4 : 32'd0);
      rd(3'd5, v, vn);
      chk($sformatf("%s counter B code %0h", has_event(d) ? "R5" : "R6", d), v,
          has_event(d) ? 32'd8 : 32'd0);
      rd(3'd2, v, vn);
      chk("R8 A high word", v, 32'h0);
    end

    // R7 elapsed time, every cycle, evt_i[35] low
    wr(3'd0, RUN | CLR | 16'h23);
    repeat (10) @(negedge clk);
    wr(3'd0, 16'h23);
    rd(3'd3, v, vn);
    chk("R7 elapsed per cycle", v, 32'd11);
    chk("R7 elapsed per cycle narrow", vn, 32'd11);

    // R7 elapsed on tick, evt_i all high
    evt = '1;
    wr(3'd0, RUN | CLR | TSRC | 16'h23);
    for (int j = 0; j < 10; j++) begin
      tick = (j % 3 == 0);
      @(negedge clk);
    end
    tick = 1'b0;
    wr(3'd0, TSRC | 16'h23);
    evt = '0;
    rd(3'd3, v, vn);
    chk("R7 elapsed on tick", v, 32'd4);

    // R3 one run bit alone does nothing
    wr(3'd0, 16'h8000 | CLR | 16'h23);
    repeat (10) @(negedge clk);
    wr(3'd0, 16'h4000 | 16'h23);
    repeat (10) @(negedge clk);
    wr(3'd0, 16'h23);
    rd(3'd3, v, vn);
    chk("R3 single run bit", v, 32'd0);

    // R3 hold after enable is cleared
    wr(3'd0, RUN | CLR | 16'h23);
    repeat (4) @(negedge clk);
    wr(3'd0, 16'h4000 | 16'h23);
    repeat (6) @(negedge clk);
    rd(3'd3, v, vn);
    chk("R3 hold after disable", v, 32'd5);

    // R4 clear beats increment, then counting resumes
    wr(3'd0, RUN | CLR | 16'h23);
    repeat (5) @(negedge clk);
    wr(3'd0, RUN | CLR | 16'h23);
    wr(3'd0, 16'h23);
    rd(3'd3, v, vn);
    chk("R4 clear priority", v, 32'd1);
    rd(3'd0, v, vn);
    chk("R4 clear bit reads zero", v, 32'h0000_0023);

    // R2 readback and bits without effect
    wr(3'd1, 16'hFFFF);
    rd(3'd1, v, vn);
    chk("R2 control readback", v, 32'h0000_DFFF);
    wr(3'd1, 16'h1EC0 | RUN | CLR | 16'h23);
    repeat (3) @(negedge clk);
    wr(3'd1, 16'h23);
    rd(3'd5, v, vn);
    chk("R2 spare bits no effect", v, 32'd4);
    rd(3'd3, v, vn);
    chk("R1 counter A untouched by B", v, 32'd1);

    // R9 wrap on the narrow instance
    wr(3'd0, RUN | CLR | 16'h23);
    repeat (69) @(negedge clk);
    wr(3'd0, 16'h23);
    rd(3'd3, v, vn);
    chk("R9 wide count 70", v, 32'd70);
    chk("R9 narrow wraps to 6", vn, 32'd6);
    rd(3'd2, v, vn);
    chk("R8 narrow high word", vn, 32'h0);
    chk("R8 wide high word", v, 32'h0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule